// File: doc/BRIEF.md
# Payload Unpack and Writeback Arbiter

This block connects a dual-port store of 256-bit words to a 24-bit stream cipher. It keeps one pending flag per word address. A pulse on `hostSet` marks a freshly written word as waiting. The arbiter reads the lowest waiting address and aligns the word according to its byte enables. It then feeds the packed 24-bit items to the cipher one at a time, in order. The cipher outputs are gathered into a fresh result word. That word goes back to the same address, and the flag is dropped.

Only one word is in flight at any time. The keystream advances once per item, so items cross the cipher boundary in exactly the order in which they sit in the word. The item count per word comes from a configuration input and is capped at ten items, which is the most that fit in 256 bits. If a host request for the in-flight address arrives while that word is being processed, the request is kept and the address is served again.

Top module: `unpack_arbiter`

## Requirements
- R1: Reset clears every pending flag and leaves the memory strobes and `txValid` low. A `hostSet` pulse raises the flag of each address in its mask on the following cycle.
- R2: When any flag is set and no word is in flight, the block issues a read of the lowest-numbered flagged address.
- R3: Let i be the index of the lowest byte enable that is set in `memRdBe`. The word read is shifted right by 8*i bits before unpacking. If no byte enable is set, the word is used unshifted.
- R4: Item k goes to the cipher as bits [24k+23:24k] of the aligned word, for k = 0, 1, 2, and so on in that order. While `txValid` is high and `txReady` is low, `txData` stays stable.
- R5: The item count n is sampled from `cfgItems` in the read cycle. Any value above 10 is treated as 10. Exactly n items are sent to the cipher and exactly n results are accepted.
- R6: Result item k is written to bits [24k+23:24k] of the written word. All bits above 24n are zero.
- R7: After the n-th result is accepted, exactly one write goes to the same address, and that address's flag is cleared on the following cycle.
- R8: No new read is issued between a read and the writeback that belongs to it.
- R9: If a `hostSet` for the in-flight address arrives after its read, the flag stays set after the writeback and the address is processed again.
- R10: A count of zero produces a writeback of an all-zero word with no cipher traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostSet | input | 32 | One pulse per address written by the host |
| cfgItems | input | 4 | Items per word (values above 10 are capped) |
| pendingFlags | output | 32 | Per-address waiting flags |
| memRdEn | output | 1 | Read strobe; data returns one cycle later |
| memWrEn | output | 1 | Writeback strobe |
| memAddr | output | 5 | Shared read/write word address |
| memRdData | input | 256 | Read data |
| memRdBe | input | 32 | Byte enables stored with the read word |
| memWrData | output | 256 | Result word |
| txValid | output | 1 | Item to the cipher is valid |
| txReady | input | 1 | Cipher accepts an item |
| txData | output | 24 | Item to the cipher |
| rxValid | input | 1 | Cipher result is valid |
| rxReady | output | 1 | Block accepts a result |
| rxData | input | 24 | Cipher result |

## Verification
The bench sweeps every item count from 0 to 12 against several byte-enable offsets, including the empty mask. A wrong alignment shift or a missing cap on the count shows up as misplaced or extra items in the written word. A cipher model whose output depends on a global item sequence exposes any reordering or any item that is dropped or repeated, because every later result would then be mismatched. A request that lands on the in-flight address checks that a design clearing the flag unconditionally loses the second pass. Three simultaneous requests check that the addresses are served in ascending order.

// File: rtl/unpack_pkg.sv
package unpack_pkg;
  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_RUN, S_WB} arbState_t;

  typedef struct packed {
    logic loadWord;
    logic txShift;
    logic rxStore;
  } dpStrobe_t;
endpackage

// File: rtl/unpack_datapath.sv
module unpack_datapath
  import unpack_pkg::*;
#(
  parameter int WORD_W    = 256,
  parameter int ITEM_W    = 24,
  parameter int MAX_ITEMS = 10,
  localparam int BE_W     = WORD_W / 8,
  localparam int BIDX_W   = $clog2(BE_W),
  localparam int IDX_W    = $clog2(MAX_ITEMS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [IDX_W-1:0]  rxIdx,
  input  logic [WORD_W-1:0] memRdData,
  input  logic [BE_W-1:0]   memRdBe,
  input  logic [ITEM_W-1:0] rxData,
  output logic [ITEM_W-1:0] txData,
  output logic [WORD_W-1:0] resultWord
);
  logic [BIDX_W-1:0] lowByte;
  logic [WORD_W-1:0] alignedWord;
  logic [WORD_W-1:0] shiftReg;

  // lowest enabled byte picks the alignment shift
  always_comb begin
    lowByte = '0;
    for (int i = BE_W - 1; i >= 0; i--) begin
      if (memRdBe[i]) lowByte = BIDX_W'(i);
    end
    alignedWord = memRdData >> {lowByte, 3'b000};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg   <= '0;
      resultWord <= '0;
    end else begin
      if (strobe.loadWord) begin
        shiftReg   <= alignedWord;
        resultWord <= '0;
      end else if (strobe.txShift) begin
        shiftReg <= shiftReg >> ITEM_W;
      end
      if (strobe.rxStore) begin
        resultWord[rxIdx*ITEM_W +: ITEM_W] <= rxData;
      end
    end
  end

  assign txData = shiftReg[ITEM_W-1:0];
endmodule

// File: rtl/unpack_control.sv
module unpack_control
  import unpack_pkg::*;
#(
  parameter int NUM_ADDR  = 32,
  parameter int MAX_ITEMS = 10,
  localparam int ADDR_W   = $clog2(NUM_ADDR),
  localparam int IDX_W    = $clog2(MAX_ITEMS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_ADDR-1:0] hostSet,
  input  logic [IDX_W-1:0]    cfgItems,
  output logic [NUM_ADDR-1:0] pendingFlags,
  output logic                memRdEn,
  output logic                memWrEn,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                txValid,
  input  logic                txReady,
  input  logic                rxValid,
  output logic                rxReady,
  output dpStrobe_t           strobe,
  output logic [IDX_W-1:0]    rxIdx
);
  arbState_t           state;
  logic [ADDR_W-1:0]   curAddr;
  logic [ADDR_W-1:0]   pickAddr;
  logic [IDX_W-1:0]    itemsN;
  logic [IDX_W-1:0]    txCnt;
  logic [IDX_W-1:0]    rxCnt;
  logic                reArm;
  logic [NUM_ADDR-1:0] clrVec;
  logic                anyPending;
  logic                lastRx;

  always_comb begin
    pickAddr = '0;
    for (int i = NUM_ADDR - 1; i >= 0; i--) begin
      if (pendingFlags[i]) pickAddr = ADDR_W'(i);
    end
  end

  assign anyPending = |pendingFlags;
  assign memRdEn    = (state == S_IDLE) && anyPending;
  assign memWrEn    = (state == S_WB);
  assign memAddr    = (state == S_IDLE) ? pickAddr : curAddr;
  assign txValid    = (state == S_RUN) && (txCnt < itemsN);
  assign rxReady    = (state == S_RUN) && (rxCnt < itemsN);
  assign rxIdx      = rxCnt;
  assign lastRx     = strobe.rxStore && ((rxCnt + 1'b1) == itemsN);

  always_comb begin
    strobe          = '0;
    strobe.loadWord = (state == S_LOAD);
    strobe.txShift  = txValid && txReady;
    strobe.rxStore  = rxValid && rxReady;
  end

  always_comb begin
    clrVec = '0;
    clrVec[curAddr] = (state == S_WB) && !reArm;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= S_IDLE;
      curAddr      <= '0;
      itemsN       <= '0;
      txCnt        <= '0;
      rxCnt        <= '0;
      reArm        <= 1'b0;
      pendingFlags <= '0;
    end else begin
      // a new request always wins over a clear in the same cycle
      pendingFlags <= (pendingFlags & ~clrVec) | hostSet;
      case (state)
        S_IDLE: begin
          if (anyPending) begin
            curAddr <= pickAddr;
            itemsN  <= (cfgItems > IDX_W'(MAX_ITEMS)) ? IDX_W'(MAX_ITEMS) : cfgItems;
            txCnt   <= '0;
            rxCnt   <= '0;
            reArm   <= hostSet[pickAddr];
            state   <= S_LOAD;
          end
        end
        S_LOAD: begin
          reArm <= reArm | hostSet[curAddr];
          state <= (itemsN == '0) ? S_WB : S_RUN;
        end
        S_RUN: begin
          reArm <= reArm | hostSet[curAddr];
          if (strobe.txShift) txCnt <= txCnt + 1'b1;
          if (strobe.rxStore) rxCnt <= rxCnt + 1'b1;
          if (lastRx) state <= S_WB;
        end
        default: begin
          state <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/unpack_arbiter.sv
module unpack_arbiter
  import unpack_pkg::*;
#(
  parameter int NUM_ADDR  = 32,
  parameter int WORD_W    = 256,
  parameter int ITEM_W    = 24,
  parameter int MAX_ITEMS = 10,
  localparam int ADDR_W   = $clog2(NUM_ADDR),
  localparam int BE_W     = WORD_W / 8,
  localparam int IDX_W    = $clog2(MAX_ITEMS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_ADDR-1:0] hostSet,
  input  logic [IDX_W-1:0]    cfgItems,
  output logic [NUM_ADDR-1:0] pendingFlags,
  output logic                memRdEn,
  output logic                memWrEn,
  output logic [ADDR_W-1:0]   memAddr,
  input  logic [WORD_W-1:0]   memRdData,
  input  logic [BE_W-1:0]     memRdBe,
  output logic [WORD_W-1:0]   memWrData,
  output logic                txValid,
  input  logic                txReady,
  output logic [ITEM_W-1:0]   txData,
  input  logic                rxValid,
  output logic                rxReady,
  input  logic [ITEM_W-1:0]   rxData
);
  dpStrobe_t        strobe;
  logic [IDX_W-1:0] rxIdx;

  unpack_control #(.NUM_ADDR(NUM_ADDR), .MAX_ITEMS(MAX_ITEMS)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostSet(hostSet), .cfgItems(cfgItems),
    .pendingFlags(pendingFlags), .memRdEn(memRdEn), .memWrEn(memWrEn),
    .memAddr(memAddr), .txValid(txValid), .txReady(txReady),
    .rxValid(rxValid), .rxReady(rxReady), .strobe(strobe), .rxIdx(rxIdx)
  );

  unpack_datapath #(.WORD_W(WORD_W), .ITEM_W(ITEM_W), .MAX_ITEMS(MAX_ITEMS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxIdx(rxIdx),
    .memRdData(memRdData), .memRdBe(memRdBe), .rxData(rxData),
    .txData(txData), .resultWord(memWrData)
  );
endmodule

// File: rtl/unpack_arbiter_chk.sv
module unpack_arbiter_chk #(
  parameter int NUM_ADDR  = 32,
  parameter int ITEM_W    = 24,
  parameter int MAX_ITEMS = 10,
  localparam int ADDR_W   = $clog2(NUM_ADDR)
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_ADDR-1:0] pendingFlags,
  input logic                memRdEn,
  input logic                memWrEn,
  input logic [ADDR_W-1:0]   memAddr,
  input logic                txValid,
  input logic                txReady,
  input logic [ITEM_W-1:0]   txData
);
  logic              busy;
  logic [ADDR_W-1:0] rdAddr;
  int                txSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      rdAddr <= '0;
      txSeen <= 0;
    end else begin
      if (memRdEn) begin
        busy   <= 1'b1;
        rdAddr <= memAddr;
        txSeen <= 0;
      end else if (txValid && txReady) begin
        txSeen <= txSeen + 1;
      end
      if (memWrEn) busy <= 1'b0;
    end
  end

  p_single_flight_r8: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> !busy);
  p_wb_same_addr_r7: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (busy && memAddr == rdAddr));
  p_read_flagged_r2: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> pendingFlags[memAddr]);
  p_tx_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txData)));
  p_item_limit_r5: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |-> (txSeen < MAX_ITEMS));
endmodule

bind unpack_arbiter unpack_arbiter_chk #(
  .NUM_ADDR(NUM_ADDR), .ITEM_W(ITEM_W), .MAX_ITEMS(MAX_ITEMS)
) u_chk (.*);

// File: tb/test_unpack_arbiter.sv
module test_unpack_arbiter;
  localparam int NA = 32, WW = 256, IW = 24, MI = 10, BW = 32, AW = 5, CW = 4;
  localparam int WD = 100000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN;
  logic [NA-1:0] hostSet;
  logic [CW-1:0] cfgItems;
  logic [NA-1:0] pendingFlags;
  logic          memRdEn, memWrEn;
  logic [AW-1:0] memAddr;
  logic [WW-1:0] memRdData, memWrData;
  logic [BW-1:0] memRdBe;
  logic          txValid, txReady, rxValid, rxReady;
  logic [IW-1:0] txData, rxData;

  unpack_arbiter i_unpack_arbiter (.*);

  logic [WW-1:0] memA [NA];
  logic [BW-1:0] beA  [NA];
  logic [AW-1:0] wrAddrLog [64];
  logic [WW-1:0] wrDataLog [64];
  logic [AW-1:0] rdAddrLog [64];
  int wrN = 0, rdN = 0, cyc = 0, seq = 0, gSeq = 0;
  int checks = 0, failures = 0, flightErr = 0;
  logic benchBusy;
  logic cHeld;
  logic [IW-1:0] cData;

  function automatic logic [IW-1:0] xf(int s);
    logic [IW-1:0] t;
    t = IW'(s) * 24'h010F07;
    return t ^ 24'h3C9A51;
  endfunction

  function automatic logic [WW-1:0] expWord(logic [WW-1:0] d, logic [BW-1:0] be, int cnt, int s0);
    int lo, n;
    logic [WW-1:0] al, res;
    lo = 0;
    for (int i = BW - 1; i >= 0; i--) if (be[i]) lo = i;
    al  = d >> (lo * 8);
    n   = (cnt > MI) ? MI : cnt;
    res = '0;
    for (int k = 0; k < n; k++) res[k*IW +: IW] = al[k*IW +: IW] ^ xf(s0 + k);
    return res;
  endfunction

  // memory model, one-cycle read latency
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (memRdEn) begin
      memRdData <= memA[memAddr];
      memRdBe   <= beA[memAddr];
    end
  end

  // logs and single-flight monitor
  always @(posedge clk) begin
    if (!rstN) begin
      benchBusy <= 1'b0;
    end else begin
      if (memRdEn) begin
        if (benchBusy) flightErr <= flightErr + 1;
        rdAddrLog[rdN[5:0]] <= memAddr;
        rdN <= rdN + 1;
        benchBusy <= 1'b1;
      end
      if (memWrEn) begin
        wrAddrLog[wrN[5:0]] <= memAddr;
        wrDataLog[wrN[5:0]] <= memWrData;
        wrN <= wrN + 1;
        benchBusy <= 1'b0;
      end
    end
  end

  // cipher model: one item held, output depends on global item sequence
  assign txReady = !cHeld && (cyc % 4 != 3);
  assign rxValid = cHeld;
  assign rxData  = cData;
  always @(posedge clk) begin
    if (!rstN) begin
      cHeld <= 1'b0;
      cData <= '0;
    end else begin
      if (rxValid && rxReady) cHeld <= 1'b0;
      if (txValid && txReady) begin
        cHeld <= 1'b1;
        cData <= txData ^ xf(seq);
        seq   <= seq + 1;
      end
    end
  end

  task automatic check(input logic ok, input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [NA-1:0] mask);
    @(negedge clk); hostSet = mask;
    @(negedge clk); hostSet = '0;
  endtask

  task automatic waitWr(input int target);
    while (wrN < target && cyc < WD) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    wait (cyc >= WD);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WD);
    finishRun();
  end

  initial begin
    logic [WW-1:0] d, dB, e;
    logic [BW-1:0] be;
    int base, rb, n, ob;
    rstN = 1'b0; hostSet = '0; cfgItems = '0;
    for (int a = 0; a < NA; a++) begin memA[a] = '0; beA[a] = '0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    check(pendingFlags == '0, "R1 flags after reset", WW'(pendingFlags), '0);
    check(!memRdEn && !memWrEn && !txValid, "R1 strobes idle in reset",
          WW'({memRdEn, memWrEn, txValid}), '0);
    rstN = 1'b1;
    @(negedge clk);

    // three simultaneous requests: order and flags
    cfgItems = 4'd3;
    memA[17] = {8{32'hA1B2C3D4}}; beA[17] = 32'h0000_0004;
    memA[5]  = {8{32'h13579BDF}}; beA[5]  = 32'hFFFF_FFFF;
    memA[2]  = {8{32'h2468ACE0}}; beA[2]  = 32'hFFFF_FF00;
    base = wrN; rb = rdN;
    pulse((NA'(1) << 2) | (NA'(1) << 5) | (NA'(1) << 17));
    check((pendingFlags & 32'h0002_0024) == 32'h0002_0024, "R1 flags raised",
          WW'(pendingFlags), WW'(32'h0002_0024));
    waitWr(base + 3);
    check(rdAddrLog[rb] == 5'd2 && rdAddrLog[rb+1] == 5'd5 && rdAddrLog[rb+2] == 5'd17,
          "R2 ascending service", WW'({rdAddrLog[rb], rdAddrLog[rb+1], rdAddrLog[rb+2]}),
          WW'({5'd2, 5'd5, 5'd17}));
    check(wrAddrLog[base] == 5'd2 && wrAddrLog[base+1] == 5'd5 && wrAddrLog[base+2] == 5'd17,
          "R7 writeback addresses", WW'({wrAddrLog[base], wrAddrLog[base+1], wrAddrLog[base+2]}),
          WW'({5'd2, 5'd5, 5'd17}));
    e = expWord(memA[2], beA[2], 3, gSeq);
    check(wrDataLog[base] == e, "R4/R6 word at 2", wrDataLog[base], e);
    e = expWord(memA[5], beA[5], 3, gSeq + 3);
    check(wrDataLog[base+1] == e, "R4/R6 word at 5", wrDataLog[base+1], e);
    e = expWord(memA[17], beA[17], 3, gSeq + 6);
    check(wrDataLog[base+2] == e, "R3 word at 17", wrDataLog[base+2], e);
    gSeq += 9;
    check(pendingFlags == '0, "R7 flags cleared", WW'(pendingFlags), '0);
    check(flightErr == 0, "R8 single word in flight", WW'(flightErr), '0);

    // sweep of counts and alignments on one address
    for (int cnt = 0; cnt <= 12; cnt++) begin
      for (int o = 0; o < 5; o++) begin
        ob = (o == 0) ? 0 : (o == 1) ? 1 : (o == 2) ? 5 : 9;
        be = (o == 4) ? '0 : (BW'('1) << ob);
        for (int j = 0; j < 8; j++)
          d[j*32 +: 32] = (32'(cnt * 7 + o + 1) * 32'h9E3779B9) ^ (32'(j) * 32'h01010101);
        memA[3] = d; beA[3] = be;
        cfgItems = CW'(cnt);
        n = (cnt > MI) ? MI : cnt;
        base = wrN;
        rb = seq;
        pulse(NA'(1) << 3);
        waitWr(base + 1);
        e = expWord(d, be, cnt, gSeq);
        if (cnt == 0)
          check(wrDataLog[base] == '0, "R10 zero count word", wrDataLog[base], '0);
        else if (cnt > MI)
          check(wrDataLog[base] == e, "R5 capped count word", wrDataLog[base], e);
        else if (o != 0)
          check(wrDataLog[base] == e, "R3 aligned word", wrDataLog[base], e);
        else
          check(wrDataLog[base] == e, "R6 packed word", wrDataLog[base], e);
        check(seq - rb == n, "R5 item count", WW'(seq - rb), WW'(n));
        check(wrAddrLog[base] == 5'd3 && !pendingFlags[3], "R7 writeback and clear",
              WW'({wrAddrLog[base], pendingFlags[3]}), WW'({5'd3, 1'b0}));
        gSeq += n;
      end
    end

    // R9: second request while in flight
    cfgItems = 4'd10;
    d  = {8{32'hCAFEF00D}};
    dB = {8{32'h0BADBEEF}};
    memA[7] = d; beA[7] = 32'h0000_0001;
    base = wrN;
    pulse(NA'(1) << 7);
    while (!txValid && cyc < WD) @(negedge clk);
    memA[7] = dB;
    pulse(NA'(1) << 7);
    waitWr(base + 1);
    check(pendingFlags[7] == 1'b1, "R9 flag kept after writeback", WW'(pendingFlags[7]), WW'(1));
    e = expWord(d, 32'h1, 10, gSeq);
    check(wrDataLog[base] == e, "R9 first pass word", wrDataLog[base], e);
    gSeq += 10;
    waitWr(base + 2);
    e = expWord(dB, 32'h1, 10, gSeq);
    check(wrDataLog[base+1] == e && wrAddrLog[base+1] == 5'd7, "R9 second pass word",
          wrDataLog[base+1], e);
    gSeq += 10;
    check(pendingFlags == '0, "R9 flag cleared after second pass", WW'(pendingFlags), '0);
    check(flightErr == 0, "R8 no overlapping reads", WW'(flightErr), '0);
    finishRun();
  end
endmodule